// File: doc/BRIEF.md
# Multiplexed-Address DRAM Sequencer

This block turns single-word host requests into strobe sequences for an asynchronous 1M x 16 dynamic RAM. The host presents a 20-bit word address, a read/write flag, two byte-lane enables and write data, and holds its request until a one-cycle ready pulse answers it. The block splits the address into a row phase and a column phase on one shared pin bus. It selects byte lanes with two separate column strobes and times every edge in whole clock cycles. All of these cycle counts come from nanosecond-style parameters and are rounded up.

When the next request falls in the row that is already open, the row stays active and only a new column cycle runs (page mode). A free-running interval counter raises a refresh demand. That demand is served with a column-strobe-before-row-strobe cycle as soon as the current access ends, and it closes any open page first. The data bus is split into an input, an output and an output-enable, which a pad ring joins into the bidirectional pins.

Top module: `dramc_top`

## Requirements
- R1: After reset, and while nothing is in progress, the row strobe, both column strobes, write enable and output enable are all high, the data output enable is low and ready is low.
- R2: Address bits [19:8] form the row. They appear on pins [11:0] before the row strobe falls and stay stable across that fall. Address bits [7:0] form the column. They appear on pins [7:0], with pins [11:8] at zero, and stay stable across the column strobe fall.
- R3: Enable bit 0 selects the low byte (data bits [7:0]) and its strobe `dram_lcas_n`. Enable bit 1 selects the high byte (data bits [15:8]) and `dram_ucas_n`. A deselected strobe stays high, and a write leaves the deselected byte in memory unchanged.
- R4: On a write, write enable is low and the data output is enabled with the request's data for at least one cycle before a column strobe falls. Output enable stays high throughout.
- R5: On a read, write enable stays high, output enable is low only while the column strobe is low, and the data output is disabled. Read data is sampled no earlier than T_RAC after the row strobe falls and no earlier than T_CAC after the column strobe falls. Deselected bytes of the returned word are zero.
- R6: Each accepted access produces exactly one ready pulse, one cycle wide. Read data is valid in that cycle.
- R7: A request to the same row, present when the column precharge ends, reuses the open row with no new row strobe fall. Successive column strobe falls are at least T_PC apart.
- R8: A request to a different row, or no request, closes the row. The row strobe then stays high for at least T_RP before it falls again.
- R9: A refresh drives both column strobes low together while the row strobe is high. The row strobe falls one or more cycles later.
- R10: A refresh demand is raised every floor(REFI_PS/CLK_PS) cycles. A pending demand wins over host requests at the next decision point: it closes an open page and starts within a bounded number of cycles.
- R11: Each timing count is the parameter time divided by the clock period, rounded up. The row-to-column delay is at least T_RCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until ready |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables (bit 0 low byte) |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, deselected bytes zero |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Low-byte column strobe, active low |
| dram_ucas_n | output | 1 | High-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_a | output | 12 | Multiplexed row/column address |
| dram_dq_in | input | 16 | Data from the memory pins |
| dram_dq_out | output | 16 | Data to the memory pins |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |

## Verification
The bench builds the block with an 8 ns clock (CLK_PS=8000), so most counts round up rather than divide exactly. With this clock, 20 ns becomes 3 cycles, 50 ns becomes 7 cycles, and the column pulse is stretched to 3 cycles so the row access time is still met. The bench also shortens the refresh interval to 600 ns (75 cycles). Several refreshes therefore land inside a short run, including one in the middle of a long same-row burst. This exercises the page-close-before-refresh path. The memory stub drives garbage until both access delays have passed, so a sampling edge that comes too early shows up as wrong read data.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RSU,
      ST_RCD,
      ST_CSU,
      ST_CAS,
      ST_CP,
      ST_RP,
      ST_CBR_SU,
      ST_CBR_RAS
   } dram_st_e;

   function automatic int cdiv(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dramc_refresh.sv
module dramc_refresh #(
   parameter int INTERVAL = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pend
);
   localparam int CW = $clog2(INTERVAL + 1);

   if (INTERVAL < 16) begin : g_bad_interval
      $error("refresh interval too short");
   end

   logic [CW-1:0] cnt;
   logic          tick;

   assign tick = (cnt == CW'(INTERVAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         cnt <= tick ? '0 : cnt + 1'b1;
         if (tick)
            pend <= 1'b1;
         else if (ack)
            pend <= 1'b0;
      end
   end

   // R10: the sequencer only starts a refresh that was demanded
   a_r10_ack_needs_pend : assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> pend);

endmodule

// File: rtl/dramc_addr_mux.sv
module dramc_addr_mux #(
   parameter int ROW_W = 12,
   parameter int COL_W = 8,
   parameter int PIN_W = 12
) (
   input  logic [ROW_W+COL_W-1:0] waddr,
   input  logic                   row_ph,
   input  logic                   col_ph,
   output logic [PIN_W-1:0]       pins
);
   localparam int AW = ROW_W + COL_W;

   if (PIN_W < ROW_W || PIN_W < COL_W) begin : g_bad_pins
      $error("pin bus narrower than an address phase");
   end

   logic [PIN_W-1:0] row_p;
   logic [PIN_W-1:0] col_p;

   if (ROW_W == PIN_W) begin : g_row_full
      assign row_p = waddr[AW-1:COL_W];
   end else begin : g_row_pad
      assign row_p = {{(PIN_W-ROW_W){1'b0}}, waddr[AW-1:COL_W]};
   end

   if (COL_W == PIN_W) begin : g_col_full
      assign col_p = waddr[COL_W-1:0];
   end else begin : g_col_pad
      assign col_p = {{(PIN_W-COL_W){1'b0}}, waddr[COL_W-1:0]};
   end

   assign pins = row_ph ? row_p : (col_ph ? col_p : '0);

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
   import dramc_pkg::*;
#(
   parameter int RCD_CYC  = 2,
   parameter int CAS_CYC  = 2,
   parameter int CP_CYC   = 1,
   parameter int RP_CYC   = 3,
   parameter int RASR_CYC = 5,
   parameter int CSR_CYC  = 1,
   parameter int TW       = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req,
   input  logic     same_row,
   input  logic     ref_pend,
   output dram_st_e st,
   output logic     take,
   output logic     ref_ack,
   output logic     done
);
   if (RCD_CYC >= 2**TW || CAS_CYC >= 2**TW || CP_CYC >= 2**TW ||
       RP_CYC >= 2**TW || RASR_CYC >= 2**TW || CSR_CYC >= 2**TW) begin : g_bad_tw
      $error("timer too narrow for a timing count");
   end

   dram_st_e      nst;
   logic [TW-1:0] tcnt;
   logic [TW-1:0] nload;
   logic          tdone;

   assign tdone = (tcnt == '0);

   always_comb begin
      nst     = st;
      nload   = tcnt - 1'b1;
      take    = 1'b0;
      ref_ack = 1'b0;
      done    = 1'b0;
      if (tdone) begin
         nload = '0;
         unique case (st)
            ST_IDLE: begin
               if (ref_pend) begin
                  nst     = ST_CBR_SU;
                  nload   = TW'(CSR_CYC - 1);
                  ref_ack = 1'b1;
               end else if (req) begin
                  nst  = ST_RSU;
                  take = 1'b1;
               end
            end
            ST_RSU: begin
               nst   = ST_RCD;
               nload = TW'(RCD_CYC - 1);
            end
            ST_RCD: nst = ST_CSU;
            ST_CSU: begin
               nst   = ST_CAS;
               nload = TW'(CAS_CYC - 1);
            end
            ST_CAS: begin
               nst   = ST_CP;
               nload = TW'(CP_CYC - 1);
               done  = 1'b1;
            end
            ST_CP: begin
               if (req && same_row && !ref_pend) begin
                  nst  = ST_CSU;
                  take = 1'b1;
               end else begin
                  nst   = ST_RP;
                  nload = TW'(RP_CYC - 1);
               end
            end
            ST_RP: nst = ST_IDLE;
            ST_CBR_SU: begin
               nst   = ST_CBR_RAS;
               nload = TW'(RASR_CYC - 1);
            end
            ST_CBR_RAS: begin
               nst   = ST_RP;
               nload = TW'(RP_CYC - 1);
            end
            default: nst = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         tcnt <= '0;
      end else begin
         st   <= nst;
         tcnt <= nload;
      end
   end

endmodule

// File: rtl/dramc_top.sv
module dramc_top
   import dramc_pkg::*;
#(
   parameter int ROW_W     = 12,
   parameter int COL_W     = 8,
   parameter int BYTE_W    = 8,
   parameter int CLK_PS    = 10000,
   parameter int T_RCD_PS  = 20000,
   parameter int T_CAC_PS  = 13000,
   parameter int T_RAC_PS  = 50000,
   parameter int T_PC_PS   = 35000,
   parameter int T_RP_PS   = 30000,
   parameter int T_RAS_PS  = 50000,
   parameter int T_CSR_PS  = 5000,
   parameter int REFI_PS   = 15600000,
   localparam int ADDR_W   = ROW_W + COL_W,
   localparam int PIN_W    = imax(ROW_W, COL_W),
   localparam int DW       = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  logic [1:0]        req_be,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DW-1:0]     req_wdata,
   output logic              ready,
   output logic [DW-1:0]     rdata,
   output logic              dram_ras_n,
   output logic              dram_lcas_n,
   output logic              dram_ucas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [PIN_W-1:0]  dram_a,
   input  logic [DW-1:0]     dram_dq_in,
   output logic [DW-1:0]     dram_dq_out,
   output logic              dram_dq_oe
);
   localparam int RCD_CYC  = imax(1, cdiv(T_RCD_PS, CLK_PS));
   localparam int CAC_CYC  = cdiv(T_CAC_PS, CLK_PS);
   localparam int RAC_CYC  = cdiv(T_RAC_PS, CLK_PS);
   localparam int CAS_CYC  = imax(1, imax(CAC_CYC, RAC_CYC - RCD_CYC - 1));
   localparam int PC_CYC   = cdiv(T_PC_PS, CLK_PS);
   localparam int CP_CYC   = imax(1, PC_CYC - CAS_CYC - 1);
   localparam int RP_CYC   = imax(1, cdiv(T_RP_PS, CLK_PS));
   localparam int RASR_CYC = imax(1, cdiv(T_RAS_PS, CLK_PS));
   localparam int CSR_CYC  = imax(1, cdiv(T_CSR_PS, CLK_PS));
   localparam int REF_CYC  = REFI_PS / CLK_PS;
   localparam int REF_LAT  = 4 + RCD_CYC + CAS_CYC + CP_CYC + RP_CYC;
   localparam int TW       = 8;

   if (RCD_CYC + 1 + CAS_CYC + CP_CYC < RASR_CYC) begin : g_bad_ras
      $error("row active time shorter than the minimum pulse");
   end
   if (REF_CYC < 2 * REF_LAT) begin : g_bad_refi
      $error("refresh interval too short for the access latency");
   end

   dram_st_e           st;
   logic               take, ref_ack, done, ref_pend, same_row;
   logic [ADDR_W-1:0]  lat_addr;
   logic               lat_we;
   logic [1:0]         lat_be;
   logic [DW-1:0]      lat_wdata;
   logic [DW-1:0]      rd_mask;
   logic               row_ph, col_ph, ras_lo, cbr, cas_on;

   assign same_row = (req_addr[ADDR_W-1:COL_W] == lat_addr[ADDR_W-1:COL_W]);

   dramc_refresh #(.INTERVAL(REF_CYC)) u_ref (
      .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend)
   );

   dramc_seq #(
      .RCD_CYC(RCD_CYC), .CAS_CYC(CAS_CYC), .CP_CYC(CP_CYC), .RP_CYC(RP_CYC),
      .RASR_CYC(RASR_CYC), .CSR_CYC(CSR_CYC), .TW(TW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .same_row(same_row),
      .ref_pend(ref_pend), .st(st), .take(take), .ref_ack(ref_ack), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_addr  <= '0;
         lat_we    <= 1'b0;
         lat_be    <= '0;
         lat_wdata <= '0;
      end else if (take) begin
         lat_addr  <= req_addr;
         lat_we    <= req_we;
         lat_be    <= req_be;
         lat_wdata <= req_wdata;
      end
   end

   assign row_ph = (st == ST_RSU) || (st == ST_RCD);
   assign col_ph = (st == ST_CSU) || (st == ST_CAS);
   assign ras_lo = (st == ST_RCD) || col_ph || (st == ST_CP) || (st == ST_CBR_RAS);
   assign cbr    = (st == ST_CBR_SU) || (st == ST_CBR_RAS);
   assign cas_on = (st == ST_CAS);

   dramc_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_amux (
      .waddr(lat_addr), .row_ph(row_ph), .col_ph(col_ph), .pins(dram_a)
   );

   assign dram_ras_n  = !ras_lo;
   assign dram_lcas_n = !((cas_on && lat_be[0]) || cbr);
   assign dram_ucas_n = !((cas_on && lat_be[1]) || cbr);
   assign dram_we_n   = !(lat_we && col_ph);
   assign dram_oe_n   = !(!lat_we && cas_on);
   assign dram_dq_oe  = lat_we && col_ph;
   assign dram_dq_out = lat_wdata;

   for (genvar b = 0; b < 2; b++) begin : g_lane
      assign rd_mask[b*BYTE_W +: BYTE_W] = lat_be[b] ? dram_dq_in[b*BYTE_W +: BYTE_W] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready <= 1'b0;
         rdata <= '0;
      end else begin
         ready <= done;
         if (done)
            rdata <= lat_we ? '0 : rd_mask;
      end
   end

   // checker state: row strobe high time and refresh pending age
   logic [7:0] ras_hi_cnt;
   logic [7:0] ref_age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_hi_cnt <= 8'hFF;
         ref_age    <= '0;
      end else begin
         ras_hi_cnt <= !dram_ras_n ? 8'd0 : (ras_hi_cnt == 8'hFF ? ras_hi_cnt : ras_hi_cnt + 8'd1);
         ref_age    <= (ref_pend && !ref_ack) ? ref_age + 8'd1 : 8'd0;
      end
   end

   a_r2_row_stable : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_ras_n) && dram_lcas_n && dram_ucas_n) |-> $stable(dram_a));

   a_r2_col_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_ras_n) |-> $stable(dram_a));

   a_r4_early_write : assert property (@(posedge clk) disable iff (!rst_n)
      (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_ras_n && !dram_we_n)
      |-> ($past(!dram_we_n) && $past(dram_dq_oe)));

   a_r5_oe_read_only : assert property (@(posedge clk) disable iff (!rst_n)
      !dram_oe_n |-> (dram_we_n && !dram_dq_oe && !dram_ras_n));

   a_r6_ready_single : assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

   a_r8_precharge : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (ras_hi_cnt >= 8'(RP_CYC)));

   a_r9_cbr_order : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_ras_n) && !dram_lcas_n) |-> (!dram_ucas_n && $past(!dram_lcas_n) && $past(!dram_ucas_n)));

   a_r10_ref_latency : assert property (@(posedge clk) disable iff (!rst_n)
      ref_age <= 8'(REF_LAT));

endmodule

// File: tb/tb_dramc_top.sv
`timescale 1ns/1ps
module tb_dramc_top;
   localparam int CLK_NS  = 8;
   localparam int HALF    = CLK_NS / 2;
   localparam int REFI_NS = 600;
   localparam int T_RCD   = 20;
   localparam int T_RAC   = 50;
   localparam int T_CAC   = 13;
   localparam int T_PC    = 35;
   localparam int T_RP    = 30;
   localparam int GAP_MAX = REFI_NS / CLK_NS + 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, req_we = 1'b0;
   logic [1:0]  req_be = 2'b00;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        ready;
   logic [15:0] rdata;
   logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n;
   logic [11:0] dram_a;
   logic [15:0] dram_dq_in = 16'hDEAD;
   logic [15:0] dram_dq_out;
   logic        dram_dq_oe;

   dramc_top #(.CLK_PS(CLK_NS*1000), .REFI_PS(REFI_NS*1000)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_be(req_be),
      .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rdata(rdata),
      .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
      .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_a(dram_a),
      .dram_dq_in(dram_dq_in), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe)
   );

   always #HALF clk = ~clk;

   int n_chk = 0, n_fail = 0, n_issued = 0, n_ready = 0, n_open = 0, n_ref = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // reference contents seen by the host, and contents held by the stub
   logic [15:0] rmem [int];
   logic [15:0] dmem [int];
   logic [19:0] cur_addr = '0;
   logic [1:0]  cur_be = '0;
   logic        cur_we = 0;
   logic [15:0] cur_wdata = '0;

   function automatic logic [15:0] dget(input int k);
      return dmem.exists(k) ? dmem[k] : 16'h0;
   endfunction
   function automatic logic [15:0] rget(input int k);
      return rmem.exists(k) ? rmem[k] : 16'h0;
   endfunction
   function automatic logic [15:0] bmask(input logic [1:0] be);
      return {{8{be[1]}}, {8{be[0]}}};
   endfunction

   // behavioural memory stub: strobe order, address phases, timing in ns
   bit          p_ras = 1, p_l = 1, p_u = 1, cbr_armed = 0, lf, uf;
   longint      tp, t_ras_fall = 0, t_ras_rise = -100000, t_cas_fall = 0;
   longint      t_last_cas = -100000, t_last_ref = 0;
   logic [11:0] open_row = '0;
   logic [15:0] w;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_ras = 1; p_l = 1; p_u = 1; cbr_armed = 0;
      end else begin
         tp = longint'($time) - HALF;
         if (ready) n_ready++;
         lf = p_l && !dram_lcas_n;
         uf = p_u && !dram_ucas_n;
         if (p_ras && !dram_ras_n) begin
            chk(tp - t_ras_rise >= T_RP, "R8", "row precharge ns", tp - t_ras_rise, T_RP);
            if (!dram_lcas_n && !dram_ucas_n) begin
               chk(cbr_armed, "R9", "column strobes low before row strobe", cbr_armed, 1);
               if (n_ref > 0)
                  chk(tp - t_last_ref <= GAP_MAX*CLK_NS, "R10", "refresh gap ns",
                      tp - t_last_ref, GAP_MAX*CLK_NS);
               n_ref++;
               t_last_ref = tp;
            end else begin
               open_row = dram_a;
               chk(dram_a == cur_addr[19:8], "R2", "row address", dram_a, cur_addr[19:8]);
               n_open++;
               t_last_cas = -100000;
            end
            t_ras_fall = tp;
         end
         if (!p_ras && dram_ras_n) begin
            t_ras_rise = tp;
            cbr_armed  = 0;
         end
         if ((lf || uf) && dram_ras_n) begin
            chk(lf && uf, "R9", "both column strobes fall together", {lf, uf}, 2'b11);
            cbr_armed = 1;
         end
         if ((lf || uf) && !dram_ras_n) begin
            chk(dram_a == {4'h0, cur_addr[7:0]}, "R2", "column address", dram_a, {4'h0, cur_addr[7:0]});
            chk({!dram_ucas_n, !dram_lcas_n} == cur_be, "R3", "strobe lanes",
                {!dram_ucas_n, !dram_lcas_n}, cur_be);
            chk(tp - t_ras_fall >= T_RCD, "R11", "row-to-column ns", tp - t_ras_fall, T_RCD);
            chk(tp - t_last_cas >= T_PC, "R7", "column cycle ns", tp - t_last_cas, T_PC);
            t_last_cas = tp;
            t_cas_fall = tp;
            if (!dram_we_n) begin
               chk(dram_dq_oe && dram_oe_n && dram_dq_out == cur_wdata, "R4", "write data driven",
                   dram_dq_out, cur_wdata);
               w = dget(int'({open_row, dram_a[7:0]}));
               if (!dram_lcas_n) w[7:0]  = dram_dq_out[7:0];
               if (!dram_ucas_n) w[15:8] = dram_dq_out[15:8];
               dmem[int'({open_row, dram_a[7:0]})] = w;
            end else begin
               chk(!dram_oe_n && !dram_dq_oe, "R5", "read strobes", {dram_oe_n, dram_dq_oe}, 2'b00);
            end
         end
         if (!dram_ras_n && !dram_oe_n && (!dram_lcas_n || !dram_ucas_n) &&
             (tp + CLK_NS - t_ras_fall >= T_RAC) && (tp + CLK_NS - t_cas_fall >= T_CAC)) begin
            w = dget(int'({open_row, dram_a[7:0]}));
            dram_dq_in = {dram_ucas_n ? 8'hA5 : w[15:8], dram_lcas_n ? 8'hA5 : w[7:0]};
         end else begin
            dram_dq_in = 16'hDEAD;
         end
         p_ras = dram_ras_n; p_l = dram_lcas_n; p_u = dram_ucas_n;
      end
   end

   task automatic access(input logic [19:0] a, input bit we, input logic [1:0] be,
                         input logic [15:0] wd);
      int waitc = 0;
      logic [15:0] exp;
      cur_addr = a; cur_we = we; cur_be = be; cur_wdata = wd;
      req_addr = a; req_we = we; req_be = be; req_wdata = wd; req = 1'b1;
      n_issued++;
      exp = rget(int'(a)) & bmask(be);
      if (we) rmem[int'(a)] = (rget(int'(a)) & ~bmask(be)) | (wd & bmask(be));
      do begin
         @(negedge clk);
         waitc++;
      end while (!ready && waitc < 300);
      if (!ready) chk(0, "R6", "ready timeout", 0, 1);
      else if (!we) chk(rdata == exp, "R5", "read data", rdata, exp);
   endtask

   task automatic go_idle(input int n);
      req = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_NS * 150000);
      chk(0, "R6", "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      int o0, r0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset and standby levels
      chk(dram_ras_n && dram_lcas_n && dram_ucas_n, "R1", "strobes high",
          {dram_ras_n, dram_lcas_n, dram_ucas_n}, 3'b111);
      chk(dram_we_n && dram_oe_n, "R1", "we/oe high", {dram_we_n, dram_oe_n}, 2'b11);
      chk(!dram_dq_oe && !ready, "R1", "bus released, no ready", {dram_dq_oe, ready}, 2'b00);

      // R7 page burst in one row with mixed lanes (R3)
      o0 = n_open;
      access(20'h12310, 1, 2'b11, 16'h1111);
      access(20'h12311, 1, 2'b01, 16'h22A2);
      access(20'h12312, 1, 2'b10, 16'h3B33);
      access(20'h12310, 1, 2'b10, 16'h4C44);
      access(20'h12310, 0, 2'b11, 16'h0);
      access(20'h12311, 0, 2'b11, 16'h0);
      access(20'h12312, 0, 2'b01, 16'h0);
      access(20'h12312, 0, 2'b10, 16'h0);
      go_idle(3);
      chk(n_open - o0 == 1, "R7", "row opens in burst", n_open - o0, 1);
      chk(!dram_ras_n == 0, "R1", "row closed when idle", dram_ras_n, 1);

      // R8 row change forces close and reopen
      o0 = n_open;
      access(20'h12400, 1, 2'b11, 16'h5A5A);
      access(20'h12310, 0, 2'b11, 16'h0);
      access(20'h12400, 0, 2'b11, 16'h0);
      go_idle(2);
      chk(n_open - o0 == 3, "R8", "row opens across row changes", n_open - o0, 3);

      // mixed rows, lanes and data (R2 R3 R5)
      for (int i = 0; i < 12; i++)
         access({12'((i * 37) % 4096), 8'((i * 13) & 255)}, 1, 2'((i % 3) + 1), 16'(i * 16'h1357 + 16'h0101));
      for (int i = 11; i >= 0; i--)
         access({12'((i * 37) % 4096), 8'((i * 13) & 255)}, 0, 2'((i % 3) + 1), 16'h0);

      // R10 refresh keeps running while idle
      r0 = n_ref;
      go_idle(400);
      chk(n_ref - r0 >= 4, "R10", "refreshes during idle", n_ref - r0, 4);

      // R10 long burst: refresh must break into the open page
      o0 = n_open;
      r0 = n_ref;
      for (int i = 0; i < 25; i++)
         access({12'h200, 8'(i)}, (i < 13), 2'b11, 16'(16'hC000 + i));
      for (int i = 0; i < 13; i++)
         access({12'h200, 8'(i)}, 0, 2'b11, 16'h0);
      go_idle(3);
      chk(n_ref - r0 >= 1, "R10", "refresh inside burst", n_ref - r0, 1);
      chk(n_open - o0 >= 2, "R10", "page reopened after refresh", n_open - o0, 2);

      chk(n_ready == n_issued, "R6", "ready pulses per access", n_ready, n_issued);
      summary();
   end

endmodule